// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital side of a 16-bit serial-input converter. A host frames a word with an active-low frame select and clocks it in, most significant bit first, on falling edges of a serial clock. A shift register collects the word. At the end of a frame with exactly sixteen clock edges the word moves into a holding (input) register. A second register, the DAC register, drives the converter code output. An active-low load strobe moves the holding register into the DAC register. If the strobe is held low throughout, the DAC register follows every good frame as soon as the frame closes.

An active-low clear forces the code output to mid-scale (0x8000, the zero-volt level of an offset-binary bipolar output). It leaves both stored registers as they were, and the clear lasts until the next DAC register load. An active-low power-down input gates the code output to 0x0000 and raises a powered-down flag. Serial writes and loads are still accepted while powered down and appear once power returns. A serial output presents the oldest bit of the shift register. This allows readback of the previous word and daisy chaining with a sixteen-bit delay. It is driven only while a frame is open and rests high otherwise.

All serial and control pins are asynchronous. Each one passes through a two-flop synchroniser into the system clock domain, and edges are detected there.

Top module: `sdac_front`

## Requirements
- R1: While the frame select is high, falling serial clock edges do not change the shift register, so a later readback returns the word held before those edges.
- R2: Within a frame, the serial data input is sampled on each falling serial clock edge and shifted in MSB first, so a word sent as bit 15 down to bit 0 lands in the registers unchanged.
- R3: With the load strobe high, completing a frame updates only the holding register; the code output keeps its value.
- R4: A falling edge on the load strobe copies the holding register into the DAC register. The code output then shows that value, and the DAC register changes on no other event except the one in R5.
- R5: While the load strobe is held low, a good frame updates the DAC register when the frame select rises.
- R6: Before each falling serial clock edge of a frame, the serial output shows the next bit, MSB first, of the shift register contents from before the frame. Sixteen edges therefore read back the previous word.
- R7: A frame with other than exactly 16 falling serial clock edges (15 or 17 were tested) leaves the holding register unchanged.
- R8: A falling edge on the clear input drives the code output to 0x8000 until the next DAC register load. Neither stored register is altered by it.
- R9: While the power-down input is low, the code output is 0x0000 and the powered-down flag is 1. Frames and loads during that time take effect and are visible after power returns.
- R10: While the frame select is high, the serial output is 1 and its enable is 0; while it is low, the enable is 1.
- R11: After reset, the code output is 0x0000, the powered-down flag is 0 and the serial output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame select (asynchronous) |
| sclk | input | 1 | Serial clock, data taken on its falling edge (asynchronous) |
| sdin | input | 1 | Serial data input |
| load_n | input | 1 | Active-low load strobe for the DAC register |
| clr_n | input | 1 | Active-low clear to mid-scale |
| pwrdn_n | input | 1 | Active-low power-down |
| sdo | output | 1 | Serial output, oldest shift register bit |
| sdo_en | output | 1 | High while the serial output is driven |
| code_out | output | 16 | Converter code |
| powered_down | output | 1 | High while the converter is powered down |

## Verification
The assertions check several properties on every cycle. The shift register stays frozen while the frame is closed. A miscounted frame cannot touch the holding register. The DAC register moves only on a load event. A clear edge leaves both stored registers intact. A pending clear with power on yields mid-scale on the next cycle, and power-down always shows a zero code. Only the bench scenarios can show the end-to-end results: MSB-first ordering, readback of the earlier word through the serial output, the automatic load when the strobe is held low, the clear lasting across a new frame, and writes made during power-down appearing once power returns.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    localparam int DATA_W = 16;
    localparam int CNT_W  = $clog2(DATA_W + 2);

    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] OFF_CODE = '0;

    // pin slots of the synchroniser bank
    localparam int PIN_FRAME = 0;
    localparam int PIN_SCLK  = 1;
    localparam int PIN_SDIN  = 2;
    localparam int PIN_LOAD  = 3;
    localparam int PIN_CLR   = 4;
    localparam int PIN_PWRDN = 5;
    localparam int NUM_PINS  = 6;
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 6'b111011;

    typedef struct packed {
        logic fell;
        logic rose;
    } edge_t;

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] dac;
        logic              mid;
    } regs_t;

    function automatic logic [DATA_W-1:0] pick_code(
        input logic              off,
        input logic              mid,
        input logic [DATA_W-1:0] dac
    );
        if (off)      return OFF_CODE;
        else if (mid) return MID_CODE;
        else          return dac;
    endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_lvl,
    input  edge_t             frame_e,
    input  logic              sclk_fell,
    input  logic              sdin_lvl,
    output logic [DATA_W-1:0] sh_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              frame_ok,
    output logic              sdo,
    output logic              sdo_en
);
    logic active;
    logic take;

    assign active = ~frame_lvl;
    assign take   = active & sclk_fell;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (take) sh_q <= {sh_q[DATA_W-2:0], sdin_lvl};
            if (frame_e.fell)
                cnt_q <= take ? CNT_W'(1) : '0;
            else if (take && cnt_q != CNT_W'(DATA_W + 1))
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign frame_ok = frame_e.rose && (cnt_q == CNT_W'(DATA_W));
    assign sdo_en   = active;
    assign sdo      = active ? sh_q[DATA_W-1] : 1'b1;
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_ok,
    input  logic [DATA_W-1:0] sh,
    input  logic              load_lvl,
    input  logic              load_fell,
    input  logic              clr_fell,
    input  logic              pwrdn_lvl,
    output regs_t             st_q,
    output logic              load_ev,
    output logic [DATA_W-1:0] code_q,
    output logic              off_q
);
    logic [DATA_W-1:0] hold_nxt;

    assign load_ev  = load_fell | (frame_ok & ~load_lvl);
    assign hold_nxt = frame_ok ? sh : st_q.hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            code_q <= OFF_CODE;
            off_q  <= 1'b0;
        end else begin
            st_q.hold <= hold_nxt;
            if (load_ev) st_q.dac <= hold_nxt;
            if (clr_fell)     st_q.mid <= 1'b1;
            else if (load_ev) st_q.mid <= 1'b0;
            code_q <= pick_code(~pwrdn_lvl, st_q.mid, st_q.dac);
            off_q  <= ~pwrdn_lvl;
        end
    end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              load_n,
    input  logic              clr_n,
    input  logic              pwrdn_n,
    output logic              sdo,
    output logic              sdo_en,
    output logic [DATA_W-1:0] code_out,
    output logic              powered_down
);
    logic [NUM_PINS-1:0] pins_raw;
    logic [NUM_PINS-1:0] pins_s;

    assign pins_raw = {pwrdn_n, clr_n, load_n, sdin, sclk, frame_n};

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_sync
        sdac_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(PIN_IDLE[i])
        ) u_sync (
            .clk(clk),
            .rst(rst),
            .d  (pins_raw[i]),
            .q  (pins_s[i])
        );
    end

    // previous levels of the pins whose edges matter
    logic frame_p, sclk_p, load_p, clr_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_p <= 1'b1;
            sclk_p  <= 1'b1;
            load_p  <= 1'b1;
            clr_p   <= 1'b1;
        end else begin
            frame_p <= pins_s[PIN_FRAME];
            sclk_p  <= pins_s[PIN_SCLK];
            load_p  <= pins_s[PIN_LOAD];
            clr_p   <= pins_s[PIN_CLR];
        end
    end

    edge_t frame_e;
    logic  sclk_fell, load_fell, clr_fell;

    assign frame_e.fell = frame_p & ~pins_s[PIN_FRAME];
    assign frame_e.rose = ~frame_p & pins_s[PIN_FRAME];
    assign sclk_fell    = sclk_p & ~pins_s[PIN_SCLK];
    assign load_fell    = load_p & ~pins_s[PIN_LOAD];
    assign clr_fell     = clr_p & ~pins_s[PIN_CLR];

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              frame_ok;

    sdac_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .frame_lvl(pins_s[PIN_FRAME]),
        .frame_e  (frame_e),
        .sclk_fell(sclk_fell),
        .sdin_lvl (pins_s[PIN_SDIN]),
        .sh_q     (sh_q),
        .cnt_q    (cnt_q),
        .frame_ok (frame_ok),
        .sdo      (sdo),
        .sdo_en   (sdo_en)
    );

    regs_t st_q;
    logic  load_ev;

    sdac_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .frame_ok (frame_ok),
        .sh       (sh_q),
        .load_lvl (pins_s[PIN_LOAD]),
        .load_fell(load_fell),
        .clr_fell (clr_fell),
        .pwrdn_lvl(pins_s[PIN_PWRDN]),
        .st_q     (st_q),
        .load_ev  (load_ev),
        .code_q   (code_out),
        .off_q    (powered_down)
    );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk
    import sdac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_lvl,
    input logic              frame_rose,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              frame_ok,
    input logic              clr_fell,
    input logic              load_ev,
    input logic              pwrdn_lvl,
    input logic [DATA_W-1:0] sh_q,
    input regs_t             st_q,
    input logic [DATA_W-1:0] code_out,
    input logic              powered_down
);
    assert_idle_shift_R1: assert property (@(posedge clk) disable iff (rst)
        frame_lvl |=> $stable(sh_q));

    assert_bad_frame_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_rose && cnt_q != CNT_W'(DATA_W)) |=> $stable(st_q.hold));

    assert_dac_on_load_R4: assert property (@(posedge clk) disable iff (rst)
        !load_ev |=> $stable(st_q.dac));

    assert_clear_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_fell && !frame_ok && !load_ev) |=> ($stable(st_q.hold) && $stable(st_q.dac)));

    assert_clear_code_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.mid && pwrdn_lvl) |=> (code_out == MID_CODE));

    assert_off_code_R9: assert property (@(posedge clk) disable iff (rst)
        powered_down |-> (code_out == OFF_CODE));
endmodule

bind sdac_front sdac_front_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_lvl   (pins_s[sdac_pkg::PIN_FRAME]),
    .frame_rose  (frame_e.rose),
    .cnt_q       (cnt_q),
    .frame_ok    (frame_ok),
    .clr_fell    (clr_fell),
    .load_ev     (load_ev),
    .pwrdn_lvl   (pins_s[sdac_pkg::PIN_PWRDN]),
    .sh_q        (sh_q),
    .st_q        (st_q),
    .code_out    (code_out),
    .powered_down(powered_down)
);

// File: tb/test_sdac_front.sv
module test_sdac_front;
    logic clk = 1'b0;
    logic rst;
    logic frame_n, sclk, sdin, load_n, clr_n, pwrdn_n;
    logic sdo, sdo_en, powered_down;
    logic [15:0] code_out;

    always #5 clk = ~clk;

    sdac_front i_sdac_front (
        .clk         (clk),
        .rst         (rst),
        .frame_n     (frame_n),
        .sclk        (sclk),
        .sdin        (sdin),
        .load_n      (load_n),
        .clr_n       (clr_n),
        .pwrdn_n     (pwrdn_n),
        .sdo         (sdo),
        .sdo_en      (sdo_en),
        .code_out    (code_out),
        .powered_down(powered_down)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    logic [15:0] m_sh, m_hold, m_dac;
    bit m_mid, m_off, m_ldlow;

    function automatic logic [15:0] m_code();
        if (m_off)      return 16'h0000;
        else if (m_mid) return 16'h8000;
        else            return m_dac;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] d, input int n, output logic [15:0] rb);
        logic [15:0] old;
        old     = m_sh;
        rb      = '0;
        frame_n = 1'b0;
        wclk(4);
        chk("R10 enable in frame", sdo_en, 1);
        for (int i = 0; i < n; i++) begin
            logic b;
            b    = (i < 16) ? d[15-i] : 1'b0;
            sdin = b;
            wclk(4);
            if (i < 16) rb[15-i] = sdo;
            sclk = 1'b0;
            wclk(4);
            sclk = 1'b1;
            m_sh = {m_sh[14:0], b};
        end
        wclk(2);
        frame_n = 1'b1;
        wclk(8);
        if (n == 16) begin
            m_hold = d;
            if (m_ldlow) begin
                m_dac = d;
                m_mid = 0;
            end
        end
        if (n >= 16) chk("R6 readback", rb, old);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wclk(6);
        load_n = 1'b1;
        wclk(6);
        m_dac = m_hold;
        m_mid = 0;
    endtask

    task automatic pulse_clear();
        clr_n = 1'b0;
        wclk(6);
        clr_n = 1'b1;
        wclk(6);
        m_mid = 1;
    endtask

    initial begin
        logic [15:0] rb;
        frame_n = 1; sclk = 1; sdin = 0; load_n = 1; clr_n = 1; pwrdn_n = 1;
        m_sh = 0; m_hold = 0; m_dac = 0; m_mid = 0; m_off = 0; m_ldlow = 0;
        rst = 1;
        wclk(5);
        rst = 0;
        wclk(4);
        chk("R11 reset code", code_out, 16'h0000);
        chk("R11 reset pd", powered_down, 0);
        chk("R11 reset sdo", sdo, 1);
        chk("R10 idle enable", sdo_en, 0);

        // R3: holding register only
        send(16'h1234, 16, rb);
        chk("R3 no output change", code_out, m_code());
        // R4 / R2: strobe load, MSB-first ordering
        pulse_load();
        chk("R4 load strobe", code_out, m_code());
        chk("R2 msb first", code_out, 16'h1234);

        send(16'hABCD, 16, rb);
        chk("R3 code kept", code_out, 16'h1234);

        // R1: clock edges with frame high are ignored
        sdin = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sclk = 1'b0; wclk(4);
            sclk = 1'b1; wclk(4);
        end
        send(16'h0000, 16, rb);
        chk("R1 idle edges ignored", rb, 16'hABCD);

        // R5: automatic load with strobe held low
        load_n = 1'b0;
        wclk(6);
        m_ldlow = 1; m_dac = m_hold; m_mid = 0;
        send(16'h0F0F, 16, rb);
        chk("R5 auto load", code_out, 16'h0F0F);
        load_n = 1'b1;
        wclk(6);
        m_ldlow = 0;

        // R7: short and long frames dropped
        send(16'hFFFF, 15, rb);
        pulse_load();
        chk("R7 short frame", code_out, 16'h0F0F);
        send(16'hF0F0, 17, rb);
        pulse_load();
        chk("R7 long frame", code_out, 16'h0F0F);

        // R8: clear to mid-scale, held until next load
        pulse_clear();
        chk("R8 clear code", code_out, 16'h8000);
        send(16'h3C3C, 16, rb);
        chk("R8 clear persists", code_out, m_code());
        pulse_load();
        chk("R8 released by load", code_out, 16'h3C3C);
        pulse_clear();
        pulse_load();
        chk("R8 registers kept", code_out, 16'h3C3C);

        // R9: power-down gating, writes accepted
        pwrdn_n = 1'b0;
        wclk(6);
        m_off = 1;
        chk("R9 off code", code_out, m_code());
        chk("R9 off flag", powered_down, 1);
        send(16'h7777, 16, rb);
        pulse_load();
        chk("R9 gated during write", code_out, 16'h0000);
        pwrdn_n = 1'b1;
        wclk(6);
        m_off = 0;
        chk("R9 after power-up", code_out, 16'h7777);
        chk("R9 flag cleared", powered_down, 0);

        chk("R10 idle sdo", sdo, 1);
        chk("R10 idle enable end", sdo_en, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R11 act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule